// File: doc/BRIEF.md
# Program Fetch Memory Router

This block sits between an instruction-fetch unit and two program stores: a 4 KB on-chip ROM and an external program memory reached over a narrow multiplexed bus. Each accepted fetch request carries a 16-bit address. The router decides where the byte comes from, returns it on a single opcode port, and marks it with a one-cycle valid pulse.

The decision uses two inputs: the external-access select and the address. When the select is high, addresses inside the on-chip window are served from ROM one cycle after acceptance. Addresses above that window always go off-chip. When the select is low, every address goes off-chip. An off-chip fetch runs a fixed sequence. First comes one latch cycle, with the low address byte driven on the shared port and the latch strobe high. Then comes a read window of a set number of cycles, with the shared port released and the program read strobe low. The opcode is sampled on the last edge of that window. The high address byte stays on its own port for the whole sequence. The first request accepted after reset is always served from address 0000H, whatever address it carries. A write port fills the ROM contents.

Top module: `prog_fetch_router`

## Requirements
- R1: With `ext_access` high, a request to 0000H..0FFFH is accepted in cycle t. In cycle t+1, `opcode_valid` is 1 and `opcode` carries the ROM byte at that address (4096-byte ROM, byte index = address bits [11:0]).
- R2: With `ext_access` high, any address from 1000H to FFFFH is fetched over the external bus.
- R3: With `ext_access` low, every address, including 0000H..0FFFH, is fetched over the external bus.
- R4: The first request accepted after reset is served from address 0000H regardless of `fetch_addr`.
- R5: An external fetch accepted in cycle t holds `ext_ale` high in cycle t+1 only. It then holds `ext_psen_n` low for RD_CYCLES cycles from t+2. The two strobes are never active in the same cycle.
- R6: During the latch cycle, `ext_ad_oe` is 1 and `ext_ad_out` holds address bits [7:0]. During the read window, `ext_ad_oe` is 0. During both, `ext_addr_hi` holds address bits [15:8].
- R7: An external fetch samples `ext_ad_in` on the last clock edge of the read window and presents it on `opcode` with `opcode_valid` = 1 in the following cycle (t+2+RD_CYCLES).
- R8: An internal fetch leaves `ext_ale` at 0 and `ext_psen_n` at 1.
- R9: `opcode_valid` is high for exactly one cycle per completed fetch. Between fetches, `opcode` keeps the last returned byte.
- R10: A request is accepted only when no external fetch is in progress. A request raised during the latch cycle or the read window is ignored: it produces no valid pulse and no extra bus sequence.
- R11: In reset (synchronous, active low): `opcode_valid` = 0, `opcode` = 0, `ext_ale` = 0, `ext_psen_n` = 1, `ext_ad_oe` = 0.
- R12: A write with `rom_wr_en` high stores `rom_wr_data` at `rom_wr_addr`, and later internal fetches of that address return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 16 | Fetch address |
| ext_access | input | 1 | High allows on-chip ROM for the low window |
| rom_wr_en | input | 1 | ROM fill write enable |
| rom_wr_addr | input | 12 | ROM fill address |
| rom_wr_data | input | 8 | ROM fill data |
| opcode | output | 8 | Returned opcode byte |
| opcode_valid | output | 1 | One-cycle pulse per completed fetch |
| ext_ad_out | output | 8 | Shared port, low address byte driven out |
| ext_ad_oe | output | 1 | Shared port output enable |
| ext_ad_in | input | 8 | Shared port, data read back |
| ext_addr_hi | output | 16-8=8 | High address byte |
| ext_ale | output | 1 | Address latch strobe, active high |
| ext_psen_n | output | 1 | Program read strobe, active low |

## Verification
The bench keeps the default 16-bit address and 12-bit ROM index, so the boundary pairs 0FFFH/1000H and FFFFH/0000H fall on the real window edge. It sets RD_CYCLES to 3 rather than the default 2, so the read-window counter has to count down through an intermediate value. This exposes an off-by-one in the sampling edge or in the strobe width. The request input is left high through whole external sequences, so ignored requests inside the window get exercised. A reset in the middle of the run checks the forced 0000H first fetch a second time.

// File: rtl/pfr_pkg.sv
// Package: shared types for the program fetch router.
// Assumes: nothing beyond IEEE 1800-2017.
package pfr_pkg;
    // Phase of the external program bus sequence.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LATCH = 2'd1,
        PH_READ  = 2'd2
    } ext_phase_e;
endpackage

// File: rtl/pfr_route_decode.sv
// Module: decides whether a fetch address is served by the on-chip ROM.
// Assumes: the ROM occupies addresses 0 .. 2**ROM_AW-1 of the program space.
module pfr_route_decode #(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_access,
    output logic              go_internal
);
    generate
        if (ADDR_W > ROM_AW) begin : g_split
            // Internal only when allowed and the upper address bits are zero.
            always_comb go_internal = ext_access && (addr[ADDR_W-1:ROM_AW] == '0);
        end else begin : g_full
            // ROM spans the whole space; the pin alone decides.
            always_comb go_internal = ext_access;
        end
    endgenerate
endmodule

// File: rtl/pfr_int_rom.sv
// Module: on-chip program ROM array with a fill port and a registered read.
// Assumes: the fill and fetch never target the same entry in the same cycle.
module pfr_int_rom #(
    parameter int ROM_AW = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROM_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ROM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ROM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Fill path: store one byte per write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Fetch path: one-cycle registered read.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/pfr_ext_seq.sv
// Module: runs the fixed external program fetch sequence (latch, read window).
// Assumes: start only when busy is low; ad_in is valid by the last read edge.
module pfr_ext_seq
    import pfr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int RD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] ad_in,
    output logic              busy,
    output logic              ale,
    output logic              psen_n,
    output logic              ad_oe,
    output logic [7:0]        ad_out,
    output logic [ADDR_W-9:0] addr_hi,
    output logic              done,
    output logic [DATA_W-1:0] done_data
);
    localparam int CNT_W = $clog2(RD_CYCLES + 1);

    ext_phase_e        phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;

    // Phase, window counter and latched address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_LATCH;
                    addr_q  <= start_addr;
                end
                PH_LATCH: begin
                    phase_q <= PH_READ;
                    cnt_q   <= CNT_W'(RD_CYCLES - 1);
                end
                PH_READ: begin
                    if (cnt_q == '0) phase_q <= PH_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Capture the opcode on the last read edge and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            done_data <= '0;
        end else begin
            done <= (phase_q == PH_READ) && (cnt_q == '0);
            if ((phase_q == PH_READ) && (cnt_q == '0)) done_data <= ad_in;
        end
    end

    // Bus pins decoded from the phase.
    always_comb begin
        busy    = (phase_q != PH_IDLE);
        ale     = (phase_q == PH_LATCH);
        ad_oe   = (phase_q == PH_LATCH);
        psen_n  = (phase_q != PH_READ);
        ad_out  = addr_q[7:0];
        addr_hi = addr_q[ADDR_W-1:8];
    end

    p_psen_follows_ale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> $past(ale));
    p_hi_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n && $past(!psen_n)) |-> $stable(addr_hi));
    p_done_after_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!psen_n));
endmodule

// File: rtl/prog_fetch_router.sv
// Module: top of the program fetch router; routes each fetch to ROM or the bus.
// Assumes: fetch_req is level; a request is taken whenever no bus fetch runs.
module prog_fetch_router #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ROM_AW    = 12,
    parameter int RD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              ext_access,
    input  logic              rom_wr_en,
    input  logic [ROM_AW-1:0] rom_wr_addr,
    input  logic [DATA_W-1:0] rom_wr_data,
    output logic [DATA_W-1:0] opcode,
    output logic              opcode_valid,
    output logic [7:0]        ext_ad_out,
    output logic              ext_ad_oe,
    input  logic [DATA_W-1:0] ext_ad_in,
    output logic [ADDR_W-9:0] ext_addr_hi,
    output logic              ext_ale,
    output logic              ext_psen_n
);
    localparam logic [ADDR_W:0] ROM_LIMIT = (ADDR_W + 1)'(1) << ROM_AW;

    logic              first_q;
    logic              seq_busy, seq_done;
    logic [DATA_W-1:0] seq_data, rom_data, hold_q;
    logic              accept, go_int, int_acc, ext_start, int_vld_q;
    logic [ADDR_W-1:0] eff_addr;

    // Request acceptance and reset-vector forcing.
    always_comb begin
        accept    = fetch_req && !seq_busy;
        eff_addr  = first_q ? '0 : fetch_addr;
        int_acc   = accept && go_int;
        ext_start = accept && !go_int;
    end

    pfr_route_decode #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_decode (
        .addr        (eff_addr),
        .ext_access  (ext_access),
        .go_internal (go_int)
    );

    pfr_int_rom #(.ROM_AW(ROM_AW), .DATA_W(DATA_W)) u_rom (
        .clk     (clk),
        .wr_en   (rom_wr_en),
        .wr_addr (rom_wr_addr),
        .wr_data (rom_wr_data),
        .rd_en   (int_acc),
        .rd_addr (eff_addr[ROM_AW-1:0]),
        .rd_data (rom_data)
    );

    pfr_ext_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYCLES(RD_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ext_start),
        .start_addr (eff_addr),
        .ad_in      (ext_ad_in),
        .busy       (seq_busy),
        .ale        (ext_ale),
        .psen_n     (ext_psen_n),
        .ad_oe      (ext_ad_oe),
        .ad_out     (ext_ad_out),
        .addr_hi    (ext_addr_hi),
        .done       (seq_done),
        .done_data  (seq_data)
    );

    // First-fetch flag and internal valid stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= 1'b1;
            int_vld_q <= 1'b0;
        end else begin
            if (accept) first_q <= 1'b0;
            int_vld_q <= int_acc;
        end
    end

    // Output select between ROM, bus result and the held last byte.
    always_comb begin
        opcode_valid = int_vld_q || seq_done;
        if (int_vld_q)     opcode = rom_data;
        else if (seq_done) opcode = seq_data;
        else               opcode = hold_q;
    end

    // Hold the last returned byte between fetches.
    always_ff @(posedge clk) begin
        if (!rst_n)            hold_q <= '0;
        else if (opcode_valid) hold_q <= opcode;
    end

    p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_ale && !ext_psen_n));
    p_internal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_acc |=> (!ext_ale && ext_psen_n));
    p_high_goes_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ({1'b0, eff_addr} >= ROM_LIMIT)) |=> ext_ale);
    p_pin_low_goes_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ext_access) |=> ext_ale);
endmodule

// File: tb/prog_fetch_router_bench.sv
module prog_fetch_router_bench;
    localparam int RD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        ext_access = 1'b1;
    logic        rom_wr_en = 1'b0;
    logic [11:0] rom_wr_addr = '0;
    logic [7:0]  rom_wr_data = '0;
    logic [7:0]  opcode, ext_ad_out, ext_ad_in, ext_addr_hi;
    logic        opcode_valid, ext_ad_oe, ext_ale, ext_psen_n;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit started = 0, done_run = 0;

    always #10 clk = ~clk;

    prog_fetch_router #(.RD_CYCLES(RD)) u_prog_fetch_router (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .ext_access(ext_access), .rom_wr_en(rom_wr_en), .rom_wr_addr(rom_wr_addr),
        .rom_wr_data(rom_wr_data), .opcode(opcode), .opcode_valid(opcode_valid),
        .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
        .ext_addr_hi(ext_addr_hi), .ext_ale(ext_ale), .ext_psen_n(ext_psen_n));

    function automatic logic [7:0] rom_fn(logic [11:0] a);
        return 8'(a[7:0] * 8'd3) ^ {a[11:8], a[11:8]};
    endfunction
    function automatic logic [7:0] ext_fn(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // External memory device: latch address on the strobe, answer while read is low.
    logic [15:0] dev_lat = '0;
    always @(posedge clk) if (ext_ale) dev_lat <= {ext_addr_hi, ext_ad_out};
    assign ext_ad_in = ext_psen_n ? 8'hEE : ext_fn(dev_lat);

    // Behavioural reference: phase 0 idle, 1 latch, 2 read window.
    int          m_phase = 0, m_cnt = 0;
    bit          m_first = 1, m_valid = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_op = '0;
    always @(posedge clk) begin
        logic [15:0] a;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_first = 1; m_valid = 0; m_addr = '0; m_op = '0;
        end else begin
            m_valid = 0;
            if (m_phase == 0) begin
                if (fetch_req) begin
                    a = m_first ? 16'h0000 : fetch_addr;
                    m_first = 0;
                    if (ext_access && a < 16'h1000) begin
                        m_valid = 1; m_op = rom_fn(a[11:0]);
                    end else begin
                        m_phase = 1; m_addr = a;
                    end
                end
            end else if (m_phase == 1) begin
                m_phase = 2; m_cnt = RD;
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_valid = 1; m_op = ext_fn(m_addr); m_phase = 0;
                end
            end
        end
        started = 1;
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (started && !done_run) begin
            chk("R9 R1 R10 R11 opcode_valid", int'(opcode_valid), int'(m_valid));
            chk("R1 R2 R3 R4 R7 R12 opcode", int'(opcode), int'(m_op));
            chk("R5 R8 R11 ext_ale", int'(ext_ale), int'(m_phase == 1));
            chk("R5 R8 R11 ext_psen_n", int'(ext_psen_n), int'(m_phase != 2));
            chk("R6 R11 ext_ad_oe", int'(ext_ad_oe), int'(m_phase == 1));
            if (m_phase == 1) chk("R6 ext_ad_out", int'(ext_ad_out), int'(m_addr[7:0]));
            if (m_phase != 0) chk("R6 ext_addr_hi", int'(ext_addr_hi), int'(m_addr[15:8]));
        end
    end

    function automatic logic [15:0] pick_addr();
        case ($urandom_range(0, 7))
            0: return 16'h0FFF;
            1: return 16'h1000;
            2: return 16'hFFFF;
            3: return 16'h0000;
            4: return 16'(16'h0F00 + $urandom_range(0, 511));
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic run_traffic(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fetch_req  = ($urandom_range(0, 9) < 7);
            fetch_addr = pick_addr();
            if ($urandom_range(0, 19) == 0) ext_access = ~ext_access;
        end
    endtask

    initial begin
        // R11: reset state observed by the per-cycle compare; R12: fill the ROM.
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            rom_wr_en = 1'b1; rom_wr_addr = 12'(i); rom_wr_data = rom_fn(12'(i));
        end
        @(negedge clk); rom_wr_en = 1'b0;
        rst_n = 1'b1;
        // R4: first request carries a non-zero address but must read 0000H.
        fetch_req = 1'b1; fetch_addr = 16'h1234; ext_access = 1'b1;
        @(negedge clk); fetch_req = 1'b0;
        // R1: internal boundary; R2: first external address.
        @(negedge clk); fetch_req = 1'b1; fetch_addr = 16'h0FFF;
        @(negedge clk); fetch_addr = 16'h1000;
        // R10: keep requesting through the bus sequence.
        repeat (RD + 3) @(negedge clk);
        fetch_req = 1'b0;
        // R3: pin low forces 0000H off-chip.
        @(negedge clk); ext_access = 1'b0; fetch_req = 1'b1; fetch_addr = 16'h0000;
        @(negedge clk); fetch_req = 1'b0;
        repeat (RD + 3) @(negedge clk);
        ext_access = 1'b1;
        run_traffic(3000);
        // R4 again after a mid-run reset, with the pin low.
        @(negedge clk); rst_n = 1'b0; fetch_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; ext_access = 1'b0; fetch_req = 1'b1; fetch_addr = 16'hBEEF;
        run_traffic(3000);
        @(negedge clk); fetch_req = 1'b0;
        repeat (10) @(negedge clk);
        done_run = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        done_run = 1;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule